// File: doc/BRIEF.md
# External Interrupt Source Combiner

This block merges three unrelated request sources onto one external interrupt request line. The sources are a general-purpose interrupt pin, the serial receive line, and a card-presence pin. The receive line is watched only for a low level, so that incoming traffic can raise an interrupt; no data is received here. Each source has its own synchroniser, trigger rule and status flag. The combined request goes to the interrupt controller. The controller returns a service acknowledge, and software writes can clear the flags.

The block holds two small registers. The select register carries the per-source enables, the general-pin polarity, the presence level and two of the flags. The control register carries the general-pin trigger type and the general-pin flag. The general-pin flag is cleared by the acknowledge. The receive and presence flags survive service and are cleared only by software.

Top module: `ext_irq_combiner`

## Requirements
- R1: After reset the select readback is 8'h00, the control readback is 2'b00 and `irqReq` is 0.
- R2: Each pin passes through a two-flop synchroniser. A pin change made before clock edge k can first change a flag at edge k+2.
- R3: With control bit 0 set to 1 (edge mode) and select bit 2 set (general enable), a high-to-low transition of the synchronised general pin sets the general flag (control bit 1). A pin that stays low does not set it again.
- R4: With control bit 0 set to 0 (level mode) and the general enable set, the general flag is set on every edge at which the synchronised pin equals select bit 3 (1 = active high, 0 = active low).
- R5: `ack`, or a control write with bit 1 at 0, clears the general flag. A set condition on the same edge wins.
- R6: With select bit 0 (receive enable) set, a low synchronised receive pin sets select bit 4. The flag is cleared only by a select write with bit 4 at 0. `ack` leaves it unchanged.
- R7: With select bit 1 (presence enable) set, the presence flag (select bit 5) is set while the synchronised presence pin equals select bit 7. It is cleared only by a select write with bit 5 at 0. `ack` leaves it unchanged.
- R8: Writing 1 to any flag bit leaves that flag unchanged. When a hardware set and a software clear meet on the same edge, the flag ends up set.
- R9: `irqReq` is high exactly when at least one flag is set together with its own source enable, and `irqEnable` and `globalEnable` are both high. It is combinational from the flags and those two inputs.
- R10: A flag whose source enable is clear is never set by its pin.
- R11: The configuration bits read back as last written: select bits 0, 1, 2, 3 and 7, and control bit 0. Select bit 6 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinGen | input | 1 | General interrupt pin, asynchronous |
| pinRx | input | 1 | Serial receive line, asynchronous |
| pinPres | input | 1 | Card-presence pin, asynchronous |
| selWrEn | input | 1 | Select register write strobe |
| selWrData | input | 8 | Select register write data |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 2 | Control register write data |
| ack | input | 1 | Interrupt service acknowledge |
| irqEnable | input | 1 | External interrupt 1 enable |
| globalEnable | input | 1 | Global interrupt enable |
| selRdData | output | 8 | Select register readback |
| ctlRdData | output | 2 | Control register readback |
| irqReq | output | 1 | Combined interrupt request |

## Verification
The general pin is driven with isolated falling edges and with long low stretches. This separates edge mode, which fires once per transition, from level mode under both polarities, which fires again after every acknowledge. The receive and presence pins are held at their active levels while clear writes, writes of one and acknowledges arrive. This shows which flags are sticky, that a same-edge hardware set beats a software clear, and that a write of one does nothing. A long stretch of random pins, writes, acknowledges and enables is checked on every clock against a behavioural model. That stretch catches latency slips of one synchroniser stage and wrong gating of the combined request.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int NUM_SRC  = 3;
  localparam int SRC_GEN  = 0;
  localparam int SRC_RX   = 1;
  localparam int SRC_PRES = 2;

  localparam int SEL_W = 8;
  localparam int CTL_W = 2;

  // select register bit positions
  localparam int SEL_RX_EN    = 0;
  localparam int SEL_PRES_EN  = 1;
  localparam int SEL_GEN_EN   = 2;
  localparam int SEL_GEN_POL  = 3;
  localparam int SEL_RX_FLAG  = 4;
  localparam int SEL_PRES_FLAG = 5;
  localparam int SEL_PRES_LVL = 7;

  // control register bit positions
  localparam int CTL_EDGE = 0;
  localparam int CTL_FLAG = 1;

  typedef struct packed {
    logic genEn;
    logic genActiveHigh;
    logic genFallEdge;
    logic rxEn;
    logic presEn;
    logic presLevel;
  } cfg_t;

  typedef struct packed {
    logic [NUM_SRC-1:0] clr;
  } strobe_t;
endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
  parameter int STAGES = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RESET_VAL}};
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             selWrEn,
  input  logic [SEL_W-1:0] selWrData,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             ack,
  output cfg_t             cfg,
  output strobe_t          stb
);
  logic unusedSelBit;
  assign unusedSelBit = selWrData[6];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else begin
      if (selWrEn) begin
        cfg.rxEn          <= selWrData[SEL_RX_EN];
        cfg.presEn        <= selWrData[SEL_PRES_EN];
        cfg.genEn         <= selWrData[SEL_GEN_EN];
        cfg.genActiveHigh <= selWrData[SEL_GEN_POL];
        cfg.presLevel     <= selWrData[SEL_PRES_LVL];
      end
      if (ctlWrEn) cfg.genFallEdge <= ctlWrData[CTL_EDGE];
    end
  end

  // clear strobes: hardware service for the general pin, write-zero for all
  always_comb begin
    stb = '0;
    stb.clr[SRC_GEN]  = ack | (ctlWrEn & ~ctlWrData[CTL_FLAG]);
    stb.clr[SRC_RX]   = selWrEn & ~selWrData[SEL_RX_FLAG];
    stb.clr[SRC_PRES] = selWrEn & ~selWrData[SEL_PRES_FLAG];
  end
endmodule

// File: rtl/extirq_datapath.sv
module extirq_datapath
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pinsAsync,
  input  cfg_t               cfg,
  input  strobe_t            stb,
  input  logic               irqEnable,
  input  logic               globalEnable,
  output logic [NUM_SRC-1:0] flags,
  output logic               irqReq
);
  logic [NUM_SRC-1:0] pinSync;
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] enMask;
  logic               genPrev;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    extirq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk (clk),
      .rstN(rstN),
      .d   (pinsAsync[i]),
      .q   (pinSync[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) genPrev <= 1'b1;
    else       genPrev <= pinSync[SRC_GEN];
  end

  always_comb begin
    hit[SRC_GEN] = cfg.genEn &
      (cfg.genFallEdge ? (genPrev & ~pinSync[SRC_GEN])
                       : (pinSync[SRC_GEN] == cfg.genActiveHigh));
    hit[SRC_RX]   = cfg.rxEn & ~pinSync[SRC_RX];
    hit[SRC_PRES] = cfg.presEn & (pinSync[SRC_PRES] == cfg.presLevel);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            flags[i] <= 1'b0;
      else if (hit[i])      flags[i] <= 1'b1;
      else if (stb.clr[i])  flags[i] <= 1'b0;
    end
  end

  always_comb begin
    enMask[SRC_GEN]  = cfg.genEn;
    enMask[SRC_RX]   = cfg.rxEn;
    enMask[SRC_PRES] = cfg.presEn;
  end

  assign irqReq = (|(flags & enMask)) & irqEnable & globalEnable;
endmodule

// File: rtl/ext_irq_combiner.sv
module ext_irq_combiner
  import extirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinGen,
  input  logic             pinRx,
  input  logic             pinPres,
  input  logic             selWrEn,
  input  logic [SEL_W-1:0] selWrData,
  input  logic             ctlWrEn,
  input  logic [CTL_W-1:0] ctlWrData,
  input  logic             ack,
  input  logic             irqEnable,
  input  logic             globalEnable,
  output logic [SEL_W-1:0] selRdData,
  output logic [CTL_W-1:0] ctlRdData,
  output logic             irqReq
);
  cfg_t               cfg;
  strobe_t            stb;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] pinsAsync;

  always_comb begin
    pinsAsync[SRC_GEN]  = pinGen;
    pinsAsync[SRC_RX]   = pinRx;
    pinsAsync[SRC_PRES] = pinPres;
  end

  extirq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .selWrEn  (selWrEn),
    .selWrData(selWrData),
    .ctlWrEn  (ctlWrEn),
    .ctlWrData(ctlWrData),
    .ack      (ack),
    .cfg      (cfg),
    .stb      (stb)
  );

  extirq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .pinsAsync   (pinsAsync),
    .cfg         (cfg),
    .stb         (stb),
    .irqEnable   (irqEnable),
    .globalEnable(globalEnable),
    .flags       (flags),
    .irqReq      (irqReq)
  );

  always_comb begin
    selRdData = '0;
    selRdData[SEL_RX_EN]     = cfg.rxEn;
    selRdData[SEL_PRES_EN]   = cfg.presEn;
    selRdData[SEL_GEN_EN]    = cfg.genEn;
    selRdData[SEL_GEN_POL]   = cfg.genActiveHigh;
    selRdData[SEL_RX_FLAG]   = flags[SRC_RX];
    selRdData[SEL_PRES_FLAG] = flags[SRC_PRES];
    selRdData[SEL_PRES_LVL]  = cfg.presLevel;
    ctlRdData = '0;
    ctlRdData[CTL_EDGE] = cfg.genFallEdge;
    ctlRdData[CTL_FLAG] = flags[SRC_GEN];
  end
endmodule

// File: rtl/extirq_checker.sv
module extirq_checker (
  input logic clk,
  input logic rstN,
  input logic irqReq,
  input logic irqEnable,
  input logic globalEnable,
  input logic ack,
  input logic selWrEn,
  input logic selWrPresFlag,
  input logic rdRxEn,
  input logic rdGenEn,
  input logic rdRxFlag,
  input logic rdPresFlag,
  input logic rdGenFlag
);
  assert_global_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !globalEnable |-> !irqReq);

  assert_local_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnable |-> !irqReq);

  assert_pres_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rdPresFlag && !(selWrEn && !selWrPresFlag)) |=> rdPresFlag);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ack && !rdGenEn) |=> !rdGenFlag);

  assert_rx_disabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!rdRxEn && !rdRxFlag) |=> !rdRxFlag);
endmodule

bind ext_irq_combiner extirq_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .irqReq       (irqReq),
  .irqEnable    (irqEnable),
  .globalEnable (globalEnable),
  .ack          (ack),
  .selWrEn      (selWrEn),
  .selWrPresFlag(selWrData[5]),
  .rdRxEn       (selRdData[0]),
  .rdGenEn      (selRdData[2]),
  .rdRxFlag     (selRdData[4]),
  .rdPresFlag   (selRdData[5]),
  .rdGenFlag    (ctlRdData[1])
);

// File: tb/tb_ext_irq_combiner.sv
module tb_ext_irq_combiner;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pinGen = 1'b1, pinRx = 1'b1, pinPres = 1'b1;
  logic selWrEn = 1'b0;
  logic [7:0] selWrData = '0;
  logic ctlWrEn = 1'b0;
  logic [1:0] ctlWrData = '0;
  logic ack = 1'b0, irqEnable = 1'b0, globalEnable = 1'b0;
  logic [7:0] selRdData;
  logic [1:0] ctlRdData;
  logic irqReq;

  int total = 0;
  int bad = 0;
  string genTag = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_combiner dut (
    .clk(clk), .rstN(rstN), .pinGen(pinGen), .pinRx(pinRx), .pinPres(pinPres),
    .selWrEn(selWrEn), .selWrData(selWrData), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .ack(ack), .irqEnable(irqEnable), .globalEnable(globalEnable),
    .selRdData(selRdData), .ctlRdData(ctlRdData), .irqReq(irqReq)
  );

  // behavioural reference model
  bit hG[$], hR[$], hP[$];
  bit mRxEn, mPresEn, mGenEn, mGenPol, mPresLvl, mEdge;
  bit mGF, mRF, mPF;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hG = '{1'b1, 1'b1, 1'b1};
      hR = '{1'b1, 1'b1, 1'b1};
      hP = '{1'b1, 1'b1, 1'b1};
      {mRxEn, mPresEn, mGenEn, mGenPol, mPresLvl, mEdge} = '0;
      {mGF, mRF, mPF} = '0;
    end else begin
      bit gHit, rHit, pHit;
      gHit = mGenEn && (mEdge ? (hG[2] && !hG[1]) : (hG[1] == mGenPol));
      rHit = mRxEn && !hR[1];
      pHit = mPresEn && (hP[1] == mPresLvl);
      if (gHit) mGF = 1;
      else if (ack || (ctlWrEn && !ctlWrData[1])) mGF = 0;
      if (rHit) mRF = 1;
      else if (selWrEn && !selWrData[4]) mRF = 0;
      if (pHit) mPF = 1;
      else if (selWrEn && !selWrData[5]) mPF = 0;
      if (selWrEn) begin
        mRxEn = selWrData[0]; mPresEn = selWrData[1]; mGenEn = selWrData[2];
        mGenPol = selWrData[3]; mPresLvl = selWrData[7];
      end
      if (ctlWrEn) mEdge = ctlWrData[0];
      hG.push_front(pinGen); void'(hG.pop_back());
      hR.push_front(pinRx);  void'(hR.pop_back());
      hP.push_front(pinPres); void'(hP.pop_back());
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit expIrq;
    logic [7:0] expCfg;
    expIrq = irqEnable && globalEnable &&
             ((mGF && mGenEn) || (mRF && mRxEn) || (mPF && mPresEn));
    expCfg = {mPresLvl, 3'b000, mGenPol, mGenEn, mPresEn, mRxEn};
    chk("R9 irqReq", irqReq, expIrq);
    chk({genTag, " general flag"}, ctlRdData[1], mGF);
    chk("R6 rx flag", selRdData[4], mRF);
    chk("R7 presence flag", selRdData[5], mPF);
    chk("R11 select config", selRdData & 8'hCF, expCfg);
    chk("R11 control mode", ctlRdData[0], mEdge);
  endtask

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic writeSel(logic [7:0] d);
    selWrEn = 1'b1; selWrData = d;
    cyc();
    selWrEn = 1'b0;
  endtask

  task automatic writeCtl(logic [1:0] d);
    ctlWrEn = 1'b1; ctlWrData = d;
    cyc();
    ctlWrEn = 1'b0;
  endtask

  task automatic pulseAck();
    ack = 1'b1;
    cyc();
    ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 select reset", selRdData, 8'h00);
    chk("R1 control reset", ctlRdData, 2'b00);
    chk("R1 irq reset", irqReq, 0);
    rstN = 1'b1;
    cyc(2);

    // R10: disabled sources never set flags
    genTag = "R10";
    irqEnable = 1'b1; globalEnable = 1'b1;
    pinGen = 1'b0; pinRx = 1'b0; pinPres = 1'b0;
    cyc(6);
    chk("R10 no flags", {ctlRdData[1], selRdData[5:4]}, 0);
    pinGen = 1'b1; pinRx = 1'b1; pinPres = 1'b1;
    cyc(4);

    // R2 / R3: edge mode, two-stage latency
    genTag = "R3";
    writeSel(8'h34);          // general enable, flag bits written 1 (no effect)
    writeCtl(2'b11);          // edge mode, flag bit 1 (no effect)
    cyc(3);
    pinGen = 1'b0;
    cyc();
    chk("R2 flag not yet after one edge", ctlRdData[1], 0);
    cyc();
    chk("R2 flag not yet after two edges", ctlRdData[1], 0);
    cyc();
    chk("R3 flag set after falling edge", ctlRdData[1], 1);
    genTag = "R5";
    pulseAck();
    cyc(5);
    chk("R3 low pin does not re-set in edge mode", ctlRdData[1], 0);
    pinGen = 1'b1; cyc(3);
    pinGen = 1'b0; cyc(4);
    writeCtl(2'b01);          // software clear of general flag
    chk("R5 write-zero clears general flag", ctlRdData[1], 0);

    // R4: level mode, both polarities
    genTag = "R4";
    writeCtl(2'b10);
    cyc(2);
    chk("R4 active-low level sets flag", ctlRdData[1], 1);
    pulseAck();
    chk("R5 level re-set wins over ack", ctlRdData[1], 1);
    writeSel(8'h3C);          // active high polarity
    pinGen = 1'b0;
    cyc(3);
    pulseAck();
    cyc(2);
    chk("R4 inactive level leaves flag clear", ctlRdData[1], 0);
    pinGen = 1'b1;
    cyc(4);
    chk("R4 active-high level sets flag", ctlRdData[1], 1);
    pulseAck();
    writeSel(8'h30);          // disable general
    pulseAck();

    // R6: receive source
    genTag = "R3";
    writeSel(8'h31);
    pinRx = 1'b0; cyc(3);
    pinRx = 1'b1; cyc(4);
    chk("R6 rx flag held after pin returns high", selRdData[4], 1);
    pulseAck();
    chk("R6 ack leaves rx flag", selRdData[4], 1);
    writeSel(8'h31);
    chk("R8 write one leaves rx flag", selRdData[4], 1);
    writeSel(8'h21);
    chk("R6 write zero clears rx flag", selRdData[4], 0);

    // R7: presence source, level select
    writeSel(8'hA2);          // presence enable, level high
    cyc(3);
    chk("R7 presence flag set at high level", selRdData[5], 1);
    pulseAck();
    chk("R7 ack leaves presence flag", selRdData[5], 1);
    writeSel(8'h82);
    chk("R8 set wins over clear", selRdData[5], 1);
    pinPres = 1'b0; cyc(3);
    writeSel(8'h82);
    chk("R7 write zero clears presence flag", selRdData[5], 0);
    cyc(3);
    chk("R7 low pin with high level leaves flag clear", selRdData[5], 0);
    writeSel(8'h22);          // level low
    cyc(2);
    chk("R7 presence flag set at low level", selRdData[5], 1);

    // R9: gating
    globalEnable = 1'b0; cyc();
    chk("R9 global gate", irqReq, 0);
    globalEnable = 1'b1; irqEnable = 1'b0; cyc();
    chk("R9 local gate", irqReq, 0);
    irqEnable = 1'b1; cyc();
    chk("R9 request with enabled flag", irqReq, 1);
    writeSel(8'h20);          // presence disabled, flag kept
    chk("R9 disabled source masks request", irqReq, 0);

    // mixed random traffic
    genTag = "R3";
    for (int i = 0; i < 4000; i++) begin
      pinGen = $urandom_range(0, 3) != 0 ? pinGen : ~pinGen;
      pinRx = $urandom_range(0, 5) == 0;
      pinPres = $urandom_range(0, 7) == 0 ? ~pinPres : pinPres;
      selWrEn = $urandom_range(0, 15) == 0;
      selWrData = 8'($urandom);
      ctlWrEn = $urandom_range(0, 15) == 0;
      ctlWrData = 2'($urandom);
      ack = $urandom_range(0, 7) == 0;
      irqEnable = $urandom_range(0, 9) != 0;
      globalEnable = $urandom_range(0, 9) != 0;
      cyc();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule